// File: doc/BRIEF.md
# Interrupt Message Write Generator

This block lets a device raise interrupts without a dedicated pin. Each internal request line that rises while the block is enabled becomes one posted memory write on the device's upstream write path. That write goes to a single programmed target address. Its 16-bit payload identifies the vector. The same upstream path also carries the device's own DMA data writes. The block merges the two streams so that an interrupt write never overtakes a DMA write that was already being offered.

Software sets the block up through a small register port. It holds the target address (low and high halves), the base payload word, an enable bit, the log2 of the number of vectors granted, and a per-vector mask. The vector index replaces the low log2(granted) bits of the payload. A request line whose number is at or above the granted count is treated as vector 0. A masked vector keeps its request pending and sends it once the mask bit is cleared.

Top module: `msi_msg_gen`

## Requirements
- R1: The grant field is ctrl bits [3:1] and holds log2 of the vector count, 0 to 5 (1 to 32 vectors). A write of 6 or 7 is stored and read back as 5.
- R2: The register port decodes these offsets: 0 = ctrl (bit 0 enable, bits [3:1] grant), 1 = address bits [31:0], 2 = address bits [63:32], 3 = payload in bits [15:0], 4 = vector mask (bit v masks vector v). Every register resets to 0 and reads back through cfg_rdata.
- R3: Every interrupt write carries the full 64-bit programmed address, whatever the vector.
- R4: The low g bits of the payload (g = grant) are the vector index, and the other payload bits come from the programmed word. up_data holds the payload in bits [15:0], with bits [31:16] at zero.
- R5: A request line numbered at or above 2^g is sent as vector 0.
- R6: Each rising edge of a request line while the block is enabled produces exactly one interrupt write.
- R7: While enable is 0, no interrupt write starts. Rising edges in that time are dropped, and requests already pending are discarded.
- R8: When several vectors are pending, the lowest-numbered eligible vector is sent first.
- R9: Only one interrupt write is outstanding. Its address and data stay stable, with up_valid high, until up_ready accepts it.
- R10: While dma_valid is high and no interrupt write is outstanding, the DMA write passes through: up_addr and up_data follow dma_addr and dma_data, and dma_ready follows up_ready. No interrupt write starts in a cycle where dma_valid is high.
- R11: A request on a masked vector stays pending, and it is sent after its mask bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| irq_req | input | 32 | Internal interrupt request lines |
| dma_valid | input | 1 | DMA write offered |
| dma_ready | output | 1 | DMA write accepted |
| dma_addr | input | 64 | DMA write address |
| dma_data | input | 32 | DMA write data |
| up_valid | output | 1 | Upstream write valid |
| up_ready | input | 1 | Upstream write ready |
| up_addr | output | 64 | Upstream write address |
| up_data | output | 32 | Upstream write data |

## Verification
Two events can meet in the same cycle: a pending interrupt becomes ready to launch just as a DMA write is offered. The bench holds dma_valid high with up_ready low and pulses a request line in that window. It then checks that the upstream port shows only the DMA write for several cycles, and that the interrupt write with the right payload appears only after the DMA write has been accepted and withdrawn. A second case, for mask release, raises a request on a masked vector and then clears the mask. The bench checks that the write appears only after the clear.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int CFG_AW   = 3;
  localparam int CFG_DW   = 32;
  localparam int GRANT_W  = 3;
  localparam int PAYLOAD_W = 16;

  typedef enum logic [CFG_AW-1:0] {
    REG_CTRL    = 3'd0,
    REG_ADDR_LO = 3'd1,
    REG_ADDR_HI = 3'd2,
    REG_PAYLOAD = 3'd3,
    REG_MASK    = 3'd4
  } reg_off_e;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter int NVEC   = 32,
  parameter bit EXT_EN = 1'b1,
  localparam int VW    = $clog2(NVEC)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [CFG_DW-1:0]     cfg_wdata,
  output logic [CFG_DW-1:0]     cfg_rdata,
  output logic                  enable,
  output logic [GRANT_W-1:0]    grant_log2,
  output logic [63:0]           tgt_addr,
  output logic [PAYLOAD_W-1:0]  base_payload,
  output logic [NVEC-1:0]       vec_mask
);
  logic                 en_q, en_d;
  logic [GRANT_W-1:0]   gr_q, gr_d;
  logic [31:0]          alo_q, alo_d;
  logic [PAYLOAD_W-1:0] pay_q, pay_d;
  logic [GRANT_W-1:0]   wr_grant;
  logic [31:0]          ahi_view;
  logic [NVEC-1:0]      mask_view;

  // grant clipped to the largest legal value
  always_comb begin
    wr_grant = cfg_wdata[3:1];
    if (wr_grant > GRANT_W'(VW)) wr_grant = GRANT_W'(VW);
  end

  always_comb begin
    en_d  = en_q;
    gr_d  = gr_q;
    alo_d = alo_q;
    pay_d = pay_q;
    if (cfg_we) begin
      case (cfg_addr)
        REG_CTRL:    begin en_d = cfg_wdata[0]; gr_d = wr_grant; end
        REG_ADDR_LO: alo_d = cfg_wdata;
        REG_PAYLOAD: pay_d = cfg_wdata[PAYLOAD_W-1:0];
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      gr_q  <= '0;
      alo_q <= '0;
      pay_q <= '0;
    end else begin
      en_q  <= en_d;
      gr_q  <= gr_d;
      alo_q <= alo_d;
      pay_q <= pay_d;
    end
  end

  generate
    if (EXT_EN) begin : g_ext
      logic [31:0]     ahi_q, ahi_d;
      logic [NVEC-1:0] msk_q, msk_d;
      always_comb begin
        ahi_d = ahi_q;
        msk_d = msk_q;
        if (cfg_we && cfg_addr == REG_ADDR_HI) ahi_d = cfg_wdata;
        if (cfg_we && cfg_addr == REG_MASK)    msk_d = cfg_wdata[NVEC-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ahi_q <= '0;
          msk_q <= '0;
        end else begin
          ahi_q <= ahi_d;
          msk_q <= msk_d;
        end
      end
      assign ahi_view  = ahi_q;
      assign mask_view = msk_q;
    end else begin : g_base
      assign ahi_view  = '0;
      assign mask_view = '0;
    end
  endgenerate

  always_comb begin
    case (cfg_addr)
      REG_CTRL:    cfg_rdata = {28'd0, gr_q, en_q};
      REG_ADDR_LO: cfg_rdata = alo_q;
      REG_ADDR_HI: cfg_rdata = ahi_view;
      REG_PAYLOAD: cfg_rdata = {16'd0, pay_q};
      REG_MASK:    cfg_rdata = CFG_DW'(mask_view);
      default:     cfg_rdata = '0;
    endcase
  end

  assign enable       = en_q;
  assign grant_log2   = gr_q;
  assign tgt_addr     = {ahi_view, alo_q};
  assign base_payload = pay_q;
  assign vec_mask     = mask_view;

  // R1: the stored grant never leaves the legal range
  a_r1_grant_range: assert property (@(posedge clk) disable iff (!rst_n)
    gr_q <= GRANT_W'(VW));
endmodule

// File: rtl/msi_pending.sv
module msi_pending
  import msi_pkg::*;
#(
  parameter int NVEC = 32,
  localparam int VW  = $clog2(NVEC)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NVEC-1:0]    irq_req,
  input  logic               enable,
  input  logic [GRANT_W-1:0] grant_log2,
  input  logic [NVEC-1:0]    vec_mask,
  input  logic               launch,
  output logic               any_ready,
  output logic [VW-1:0]      sel_vec
);
  logic [NVEC-1:0] req_q;
  logic [NVEC-1:0] pend_q, pend_d;
  logic [NVEC-1:0] rising, in_range, set_vec, eligible, clr_vec;
  logic [31:0]     granted;

  assign granted = 32'd1 << grant_log2;
  assign rising  = irq_req & ~req_q;

  // fold: lines above the grant land on vector 0
  generate
    for (genvar i = 0; i < NVEC; i++) begin : g_fold
      assign in_range[i] = (32'(i) < granted);
      if (i == 0) begin : g_v0
        assign set_vec[0] = rising[0] | (|(rising & ~in_range));
      end else begin : g_vn
        assign set_vec[i] = rising[i] & in_range[i];
      end
    end
  endgenerate

  assign eligible  = pend_q & ~vec_mask;
  assign any_ready = enable & (|eligible);

  always_comb begin
    sel_vec = '0;
    for (int i = NVEC-1; i >= 0; i--) begin
      if (eligible[i]) sel_vec = VW'(i);
    end
  end

  always_comb begin
    clr_vec = '0;
    if (launch) clr_vec[sel_vec] = 1'b1;
  end

  always_comb begin
    if (!enable) pend_d = '0;
    else         pend_d = (pend_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= irq_req;
      pend_q <= pend_d;
    end
  end

  // R7: a disabled cycle leaves nothing pending behind it
  a_r7_disable_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> pend_q == '0);
  // R11: a launched vector is never masked
  a_r11_no_masked_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !vec_mask[sel_vec]);
  // R8: the chosen vector has no lower eligible neighbour
  a_r8_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> ((eligible & ((NVEC'(1) << sel_vec) - NVEC'(1))) == '0));
endmodule

// File: rtl/msi_wr_merge.sv
module msi_wr_merge
  import msi_pkg::*;
#(
  parameter int NVEC   = 32,
  parameter int DMA_DW = 32,
  localparam int VW    = $clog2(NVEC)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 any_ready,
  input  logic [VW-1:0]        sel_vec,
  input  logic [GRANT_W-1:0]   grant_log2,
  input  logic [63:0]          tgt_addr,
  input  logic [PAYLOAD_W-1:0] base_payload,
  output logic                 launch,
  input  logic                 dma_valid,
  output logic                 dma_ready,
  input  logic [63:0]          dma_addr,
  input  logic [DMA_DW-1:0]    dma_data,
  output logic                 up_valid,
  input  logic                 up_ready,
  output logic [63:0]          up_addr,
  output logic [DMA_DW-1:0]    up_data
);
  logic                 busy_q, busy_d;
  logic [63:0]          maddr_q, maddr_d;
  logic [PAYLOAD_W-1:0] mdata_q, mdata_d;
  logic [PAYLOAD_W-1:0] low_bits, payload;

  assign low_bits = PAYLOAD_W'((32'd1 << grant_log2) - 32'd1);
  assign payload  = (base_payload & ~low_bits) | (PAYLOAD_W'(sel_vec) & low_bits);

  // an offered DMA write always goes ahead of a new interrupt write
  assign launch = !busy_q && !dma_valid && any_ready;

  always_comb begin
    busy_d  = busy_q;
    maddr_d = maddr_q;
    mdata_d = mdata_q;
    if (launch) begin
      busy_d  = 1'b1;
      maddr_d = tgt_addr;
      mdata_d = payload;
    end else if (busy_q && up_ready) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      maddr_q <= '0;
      mdata_q <= '0;
    end else begin
      busy_q  <= busy_d;
      maddr_q <= maddr_d;
      mdata_q <= mdata_d;
    end
  end

  assign up_valid  = busy_q | dma_valid;
  assign up_addr   = busy_q ? maddr_q : dma_addr;
  assign up_data   = busy_q ? DMA_DW'(mdata_q) : dma_data;
  assign dma_ready = !busy_q && up_ready;

  // R9: an unaccepted interrupt write holds still
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !up_ready) |=> (busy_q && up_valid && $stable(up_addr) && $stable(up_data)));
  // R10: an offered DMA write blocks a new interrupt write
  a_r10_dma_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && dma_valid) |=> !$rose(busy_q));
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
  import msi_pkg::*;
#(
  parameter int NVEC   = 32,
  parameter int DMA_DW = 32,
  parameter bit EXT_EN = 1'b1,
  localparam int VW    = $clog2(NVEC)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [NVEC-1:0]   irq_req,
  input  logic              dma_valid,
  output logic              dma_ready,
  input  logic [63:0]       dma_addr,
  input  logic [DMA_DW-1:0] dma_data,
  output logic              up_valid,
  input  logic              up_ready,
  output logic [63:0]       up_addr,
  output logic [DMA_DW-1:0] up_data
);
  logic                 enable;
  logic [GRANT_W-1:0]   grant_log2;
  logic [63:0]          tgt_addr;
  logic [PAYLOAD_W-1:0] base_payload;
  logic [NVEC-1:0]      vec_mask;
  logic                 any_ready, launch;
  logic [VW-1:0]        sel_vec;

  msi_cfg_regs #(.NVEC(NVEC), .EXT_EN(EXT_EN)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .enable(enable),
    .grant_log2(grant_log2), .tgt_addr(tgt_addr),
    .base_payload(base_payload), .vec_mask(vec_mask)
  );

  msi_pending #(.NVEC(NVEC)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .enable(enable),
    .grant_log2(grant_log2), .vec_mask(vec_mask), .launch(launch),
    .any_ready(any_ready), .sel_vec(sel_vec)
  );

  msi_wr_merge #(.NVEC(NVEC), .DMA_DW(DMA_DW)) u_merge (
    .clk(clk), .rst_n(rst_n), .any_ready(any_ready), .sel_vec(sel_vec),
    .grant_log2(grant_log2), .tgt_addr(tgt_addr),
    .base_payload(base_payload), .launch(launch),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
    .dma_data(dma_data), .up_valid(up_valid), .up_ready(up_ready),
    .up_addr(up_addr), .up_data(up_data)
  );

  // R7: no interrupt write starts while disabled
  a_r7_no_launch_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !launch);
endmodule

// File: tb/sim_msi_msg_gen.sv
module sim_msi_msg_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [31:0] irq_req;
  logic        dma_valid, dma_ready, up_valid, up_ready;
  logic [63:0] dma_addr, up_addr;
  logic [31:0] dma_data, up_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  msi_msg_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
    .dma_data(dma_data), .up_valid(up_valid), .up_ready(up_ready),
    .up_addr(up_addr), .up_data(up_data)
  );

  localparam logic [63:0] TGT = 64'h0000_00AB_FEE0_1000;

  // {grant[2:0], base payload[15:0], line[4:0], expected payload[15:0]}
  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {3'd0, 16'hABCD, 5'd3,  16'hABCD},
    {3'd2, 16'h1234, 5'd3,  16'h1237},
    {3'd5, 16'hFFFF, 5'd17, 16'hFFF1},
    {3'd3, 16'h00F0, 5'd9,  16'h00F0},
    {3'd4, 16'h5555, 5'd10, 16'h555A},
    {3'd1, 16'h8001, 5'd1,  16'h8001},
    {3'd7, 16'h0000, 5'd31, 16'h001F}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic pulse(input logic [31:0] lines);
    @(negedge clk);
    irq_req = lines;
    @(negedge clk);
    irq_req = '0;
  endtask

  // waits at negedges for up_valid; returns at a negedge with it seen
  task automatic wait_up(output bit got, output logic [63:0] a, output logic [31:0] d);
    got = 1'b0; a = '0; d = '0;
    for (int k = 0; k < 12; k++) begin
      if (up_valid) begin got = 1'b1; a = up_addr; d = up_data; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit got;
    logic [63:0] a;
    logic [31:0] d;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    irq_req = '0; dma_valid = 1'b0; dma_addr = '0; dma_data = '0; up_ready = 1'b1;
    repeat (3) @(negedge clk);
    // reset state (R2)
    chk("R2 reset up_valid", 64'(up_valid), 64'd0);
    for (int r = 0; r < 5; r++) begin
      rd(3'(r), d);
      chk("R2 reset register", 64'(d), 64'd0);
    end
    rst_n = 1'b1;

    wr(3'd1, TGT[31:0]);
    wr(3'd2, TGT[63:32]);
    rd(3'd2, d); chk("R2 addr high readback", 64'(d), 64'(TGT[63:32]));

    // table walk: payload composition, folding, grant clipping
    for (int i = 0; i < NV; i++) begin
      wr(3'd3, {16'd0, VEC[i][36:21]});
      wr(3'd0, {28'd0, VEC[i][39:37], 1'b1});
      pulse(32'd1 << VEC[i][20:16]);
      wait_up(got, a, d);
      chk("R6 message issued", 64'(got), 64'd1);
      chk("R3 message address", a, TGT);
      chk("R4/R5 message payload", 64'(d), 64'(VEC[i][15:0]));
      @(negedge clk);
    end
    rd(3'd0, d); chk("R1 grant 7 clipped to 5", 64'(d), 64'h0B);

    // R6: one write per edge, none after
    wr(3'd0, {28'd0, 3'd3, 1'b1});
    wr(3'd3, 32'h0000_7700);
    pulse(32'h4);
    wait_up(got, a, d);
    chk("R6 single edge message", 64'(d), 64'h7702);
    @(negedge clk);
    wait_up(got, a, d);
    chk("R6 no duplicate write", 64'(got), 64'd0);

    // R7: disabled drops requests
    wr(3'd0, {28'd0, 3'd3, 1'b0});
    pulse(32'h2);
    wait_up(got, a, d);
    chk("R7 no write while disabled", 64'(got), 64'd0);
    wr(3'd0, {28'd0, 3'd3, 1'b1});
    wait_up(got, a, d);
    chk("R7 dropped request stays dropped", 64'(got), 64'd0);

    // R8: lowest vector first
    pulse(32'h24);
    wait_up(got, a, d);
    chk("R8 first is vector 2", 64'(d), 64'h7702);
    @(negedge clk);
    wait_up(got, a, d);
    chk("R8 second is vector 5", 64'(d), 64'h7705);
    @(negedge clk);

    // R11: masked vector waits for unmask
    wr(3'd4, 32'h10);
    pulse(32'h10);
    wait_up(got, a, d);
    chk("R11 masked stays quiet", 64'(got), 64'd0);
    wr(3'd4, 32'h0);
    wait_up(got, a, d);
    chk("R11 sent after unmask", 64'(d), 64'h7704);
    @(negedge clk);

    // R9: held stable under backpressure
    up_ready = 1'b0;
    pulse(32'h8);
    wait_up(got, a, d);
    repeat (3) @(negedge clk);
    chk("R9 valid held", 64'(up_valid), 64'd1);
    chk("R9 data held", 64'(up_data), 64'h7703);
    up_ready = 1'b1;
    @(negedge clk);
    chk("R9 released after accept", 64'(up_valid), 64'd0);

    // R10: DMA write offered in the launch window goes first
    dma_addr = 64'h1111_2222_3333_4440; dma_data = 32'hCAFE_F00D;
    up_ready = 1'b0;
    @(negedge clk);
    dma_valid = 1'b1;
    pulse(32'h40);
    repeat (3) @(negedge clk);
    chk("R10 DMA address on port", up_addr, 64'h1111_2222_3333_4440);
    chk("R10 DMA data on port", 64'(up_data), 64'hCAFE_F00D);
    chk("R10 dma_ready follows up_ready", 64'(dma_ready), 64'd0);
    up_ready = 1'b1;
    #1 chk("R10 dma_ready with up_ready", 64'(dma_ready), 64'd1);
    @(negedge clk);
    dma_valid = 1'b0;
    #1 chk("R10 message not yet out", 64'(up_valid), 64'd0);
    @(negedge clk);
    wait_up(got, a, d);
    chk("R10 message after DMA", 64'(d), 64'h7706);
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule